// File: doc/BRIEF.md
# Alias-Access Register Bank for a Serial Port

This block is the software-facing register bank of a serial port controller. A single 32-bit bus port reaches three registers (control, status and a second control word), each at four consecutive word addresses. The first address reads and writes the register directly. The other three addresses are alias addresses that clear, set or invert only the bits written as one. Software can therefore change a single field without a read-modify-write sequence.

The bank also holds a 9-bit baud divider and a data-buffer address. The data-buffer address turns a write into a push strobe toward the transmit FIFO and a read into a pop strobe from the receive FIFO. The FIFOs and the shift engine sit outside the bank. They report their fill levels and emptiness on input ports, and they signal error events as one-cycle pulses.

Each error pulse sets a sticky flag. The sticky flags feed a single level-sensitive fault interrupt, and an enable bit in the second control word gates each cause.

Top module: `sport_csr_bank`

## Requirements
- R1: After reset, control, control2, baud and all sticky flags read zero, and `fault_irq` is low.
- R2: A write to word 0x00 replaces the whole control register, and a write to 0x40 replaces the whole control2 register. A read of the same address returns the value written.
- R3: A write to 0x04 (control) or 0x44 (control2) clears exactly the bits written as 1 and leaves every other bit unchanged.
- R4: A write to 0x08 or 0x48 sets exactly the bits written as 1 and leaves every other bit unchanged.
- R5: A write to 0x0C or 0x4C inverts exactly the bits written as 1 and leaves every other bit unchanged.
- R6: A read of any alias address (0x04, 0x08, 0x0C, 0x44, 0x48, 0x4C) returns the current value of its base register.
- R7: The baud register at 0x30 keeps only `wdata[8:0]`. Bits [31:9] always read 0.
- R8: Status (0x10) reads live values. Bits [28:24] hold the receive level, bits [20:16] hold the transmit level, and bit 5 is 1 when the receive FIFO is empty. Writes to the status base, set alias or invert alias have no effect on anything the status read returns.
- R9: A one-cycle pulse on `ovf_evt`, `urun_evt` or `frm_evt` sets status bit 6, 8 or 12 respectively. The bit stays 1 until software writes 1 to the same bit at the status clear alias 0x14.
- R10: When an error pulse and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R11: `fault_irq` is the OR of three terms. Each term is a sticky flag ANDed with its enable: underrun with control2 bit 10, overflow with bit 11, and frame error with bit 12.
- R12: Reads of reserved offsets (0x24 to 0x2C, 0x34 to 0x3C, and 0x50 and above) return 0. Writes to reserved offsets change no register.
- R13: A write to 0x20 raises `tx_push` for exactly that cycle, with `tx_wdata` equal to `wdata`. A read of 0x20 returns `rx_rdata` and raises `rx_pop` for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address; bits [1:0] ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| tx_level | input | 5 | Transmit FIFO fill level |
| rx_level | input | 5 | Receive FIFO fill level |
| rx_empty | input | 1 | Receive FIFO empty |
| ovf_evt | input | 1 | Receive overflow pulse |
| urun_evt | input | 1 | Transmit underrun pulse |
| frm_evt | input | 1 | Frame error pulse |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_wdata | output | 32 | Data pushed into the transmit FIFO |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_rdata | input | 32 | Head of the receive FIFO |
| ctrl_o | output | 32 | Control register value |
| ctrl2_o | output | 32 | Control2 register value |
| baud_o | output | 9 | Baud divider |
| fault_irq | output | 1 | Combined fault interrupt (level) |

## Verification
A hardware error pulse and a software clear of the same sticky flag can occur in the same cycle. The bench provokes this by raising `urun_evt` in the cycle that writes bit 8 to the status clear alias. It then reads status and requires bit 8 still set with the interrupt still high. A following lone clear must drop both the flag and the interrupt. The enable gating is judged by the same means: an overflow pulse with its enable off must leave the interrupt low while the flag still reads set.

// File: rtl/sport_csr_pkg.sv
package sport_csr_pkg;

    localparam int DATA_W = 32;
    localparam int BAUD_W = 9;
    localparam int LVL_W  = 5;

    // word indices (byte offset / 4)
    localparam int W_CTRL  = 0;
    localparam int W_STAT  = 4;
    localparam int W_BUF   = 8;
    localparam int W_BAUD  = 12;
    localparam int W_CTRL2 = 16;

    // status bit positions
    localparam int B_RXEMPTY = 5;
    localparam int B_OVF     = 6;
    localparam int B_URUN    = 8;
    localparam int B_FRM     = 12;
    localparam int B_TXLVL   = 16;
    localparam int B_RXLVL   = 24;

    // control2 enable positions
    localparam int E_URUN = 10;
    localparam int E_OVF  = 11;
    localparam int E_FRM  = 12;

    typedef enum logic [2:0] {
        OP_NONE, OP_WRITE, OP_CLEAR, OP_SET, OP_TOGGLE
    } alias_op_e;

    typedef enum logic [2:0] {
        T_NONE, T_CTRL, T_STAT, T_CTRL2, T_BAUD, T_BUF
    } target_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] ctrl2;
        logic [BAUD_W-1:0] baud;
        logic              ovf;
        logic              urun;
        logic              frm;
    } bank_t;

endpackage

// File: rtl/sport_csr_decode.sv
module sport_csr_decode
    import sport_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output target_e           tgt,
    output alias_op_e         op
);
    logic [ADDR_W-3:0] word;
    alias_op_e         sub_op;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        case (word[1:0])
            2'd0:    sub_op = OP_WRITE;
            2'd1:    sub_op = OP_CLEAR;
            2'd2:    sub_op = OP_SET;
            default: sub_op = OP_TOGGLE;
        endcase
    end

    always_comb begin
        tgt = T_NONE;
        op  = OP_NONE;
        if ((int'(word) >> 2) == (W_CTRL >> 2)) begin
            tgt = T_CTRL;  op = sub_op;
        end else if ((int'(word) >> 2) == (W_STAT >> 2)) begin
            tgt = T_STAT;  op = sub_op;
        end else if ((int'(word) >> 2) == (W_CTRL2 >> 2)) begin
            tgt = T_CTRL2; op = sub_op;
        end else if (int'(word) == W_BUF) begin
            tgt = T_BUF;   op = OP_WRITE;
        end else if (int'(word) == W_BAUD) begin
            tgt = T_BAUD;  op = OP_WRITE;
        end
    end
endmodule

// File: rtl/sport_csr_alias.sv
module sport_csr_alias
    import sport_csr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  alias_op_e    op,
    output logic [W-1:0] nxt
);
    always_comb begin
        case (op)
            OP_WRITE:  nxt = wdata;
            OP_CLEAR:  nxt = cur & ~wdata;
            OP_SET:    nxt = cur | wdata;
            OP_TOGGLE: nxt = cur ^ wdata;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/sport_csr_fault.sv
module sport_csr_fault #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         irq
);
    logic [N-1:0] hit;
    for (genvar i = 0; i < N; i++) begin : g_cause
        assign hit[i] = flags[i] & enables[i];
    end
    assign irq = |hit;
endmodule

// File: rtl/sport_csr_bank.sv
module sport_csr_bank
    import sport_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_empty,
    input  logic              ovf_evt,
    input  logic              urun_evt,
    input  logic              frm_evt,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_wdata,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_rdata,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] ctrl2_o,
    output logic [BAUD_W-1:0] baud_o,
    output logic              fault_irq
);
    target_e           tgt;
    alias_op_e         op;
    bank_t             st_d, st_q;
    logic [DATA_W-1:0] ctrl_nxt, ctrl2_nxt, stat_view;
    logic              clr_ovf, clr_urun, clr_frm;

    sport_csr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .tgt(tgt), .op(op));

    sport_csr_alias #(.W(DATA_W)) u_ctrl (
        .cur(st_q.ctrl), .wdata(wdata), .op(op), .nxt(ctrl_nxt));
    sport_csr_alias #(.W(DATA_W)) u_ctrl2 (
        .cur(st_q.ctrl2), .wdata(wdata), .op(op), .nxt(ctrl2_nxt));

    sport_csr_fault #(.N(3)) u_fault (
        .flags  ({st_q.frm, st_q.ovf, st_q.urun}),
        .enables({st_q.ctrl2[E_FRM], st_q.ctrl2[E_OVF], st_q.ctrl2[E_URUN]}),
        .irq    (fault_irq));

    // only the clear alias reaches the sticky flags
    always_comb begin
        clr_ovf  = 1'b0;
        clr_urun = 1'b0;
        clr_frm  = 1'b0;
        if (wr_en && tgt == T_STAT && op == OP_CLEAR) begin
            clr_ovf  = wdata[B_OVF];
            clr_urun = wdata[B_URUN];
            clr_frm  = wdata[B_FRM];
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && tgt == T_CTRL)  st_d.ctrl  = ctrl_nxt;
        if (wr_en && tgt == T_CTRL2) st_d.ctrl2 = ctrl2_nxt;
        if (wr_en && tgt == T_BAUD)  st_d.baud  = wdata[BAUD_W-1:0];
        // a hardware event outranks a simultaneous software clear
        st_d.ovf  = (st_q.ovf  & ~clr_ovf)  | ovf_evt;
        st_d.urun = (st_q.urun & ~clr_urun) | urun_evt;
        st_d.frm  = (st_q.frm  & ~clr_frm)  | frm_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_view                        = '0;
        stat_view[B_RXEMPTY]             = rx_empty;
        stat_view[B_OVF]                 = st_q.ovf;
        stat_view[B_URUN]                = st_q.urun;
        stat_view[B_FRM]                 = st_q.frm;
        stat_view[B_TXLVL +: LVL_W]      = tx_level;
        stat_view[B_RXLVL +: LVL_W]      = rx_level;
    end

    always_comb begin
        case (tgt)
            T_CTRL:  rdata = st_q.ctrl;
            T_STAT:  rdata = stat_view;
            T_CTRL2: rdata = st_q.ctrl2;
            T_BAUD:  rdata = {{(DATA_W-BAUD_W){1'b0}}, st_q.baud};
            T_BUF:   rdata = rx_rdata;
            default: rdata = '0;
        endcase
    end

    assign tx_push  = wr_en && tgt == T_BUF;
    assign tx_wdata = wdata;
    assign rx_pop   = rd_en && tgt == T_BUF;
    assign ctrl_o   = st_q.ctrl;
    assign ctrl2_o  = st_q.ctrl2;
    assign baud_o   = st_q.baud;

    // R3: cleared bits are zero after a clear-alias write
    p_ctrl_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == T_CTRL && op == OP_CLEAR) |=> ((ctrl_o & $past(wdata)) == '0));

    // R4: set bits are one after a set-alias write
    p_ctrl_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == T_CTRL && op == OP_SET) |=> ((ctrl_o & $past(wdata)) == $past(wdata)));

    // R7: baud keeps the low field of the written word
    p_baud_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == T_BAUD) |=> (baud_o == $past(wdata[BAUD_W-1:0])));

    // R9 and R10: an event always leaves its flag set
    p_evt_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt || urun_evt || frm_evt) |=>
        ((!$past(ovf_evt) || st_q.ovf) && (!$past(urun_evt) || st_q.urun) &&
         (!$past(frm_evt) || st_q.frm)));

    // R11: interrupt needs at least one sticky flag
    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |-> (st_q.ovf || st_q.urun || st_q.frm));

    // R12: reserved writes change no register
    p_reserved_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == T_NONE) |=> ($stable(ctrl_o) && $stable(ctrl2_o) && $stable(baud_o)));
endmodule

// File: tb/sport_csr_bank_tb.sv
module sport_csr_bank_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata, tx_wdata, rx_rdata = '0, ctrl_o, ctrl2_o;
    logic [4:0]  tx_level = '0, rx_level = '0;
    logic        rx_empty = 1, ovf_evt = 0, urun_evt = 0, frm_evt = 0;
    logic        tx_push, rx_pop, fault_irq;
    logic [8:0]  baud_o;

    int total = 0, fails = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sport_csr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_level(tx_level), .rx_level(rx_level),
        .rx_empty(rx_empty), .ovf_evt(ovf_evt), .urun_evt(urun_evt), .frm_evt(frm_evt),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .ctrl_o(ctrl_o), .ctrl2_o(ctrl2_o), .baud_o(baud_o), .fault_irq(fault_irq));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each read with the scoreboard head
    always @(negedge clk) begin
        if (rd_en && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata === e, t, rdata, e);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        rd_en = 1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic pulse_ovf();
        @(posedge clk); #1; ovf_evt = 1;
        @(posedge clk); #1; ovf_evt = 0;
    endtask

    task automatic pulse_frm();
        @(posedge clk); #1; frm_evt = 1;
        @(posedge clk); #1; frm_evt = 0;
    endtask

    task automatic irq_is(input bit e, input string t);
        @(negedge clk);
        check(fault_irq === e, t, {31'b0, fault_irq}, {31'b0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        // R1 reset state
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h40, 32'h0, "R1 ctrl2");
        rd(8'h30, 32'h0, "R1 baud");
        rd(8'h10, 32'h0000_0020, "R1 status");
        irq_is(0, "R1 irq");
        // R2, R6
        wr(8'h00, 32'h0001_8020);
        rd(8'h00, 32'h0001_8020, "R2 ctrl");
        rd(8'h04, 32'h0001_8020, "R6 clr alias read");
        rd(8'h08, 32'h0001_8020, "R6 set alias read");
        rd(8'h0C, 32'h0001_8020, "R6 inv alias read");
        // R3, R4, R5 on control
        wr(8'h04, 32'h0000_0020);
        rd(8'h00, 32'h0001_8000, "R3 ctrl clear");
        wr(8'h08, 32'h0000_2000);
        rd(8'h00, 32'h0001_A000, "R4 ctrl set");
        wr(8'h0C, 32'h0001_0001);
        rd(8'h00, 32'h0000_A001, "R5 ctrl invert");
        // control2
        wr(8'h40, 32'h0000_1C00);
        rd(8'h40, 32'h0000_1C00, "R2 ctrl2");
        wr(8'h44, 32'h0000_0400);
        rd(8'h48, 32'h0000_1800, "R3 ctrl2 clear");
        wr(8'h48, 32'h0000_0400);
        rd(8'h4C, 32'h0000_1C00, "R4 ctrl2 set");
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h40, 32'hFFFF_E3FF, "R5 ctrl2 invert");
        wr(8'h40, 32'h0000_1C00);
        // R7 baud
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, 32'h0000_01FF, "R7 baud mask");
        wr(8'h30, 32'h0000_0123);
        rd(8'h30, 32'h0000_0123, "R7 baud value");
        // R8 live status, writes ignored
        tx_level = 5'd17; rx_level = 5'd9; rx_empty = 0;
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0911_0000, "R8 live status");
        irq_is(0, "R8 no irq from status write");
        tx_level = 0; rx_level = 0; rx_empty = 1;
        // R9, R11
        pulse_ovf();
        irq_is(1, "R11 ovf irq");
        rd(8'h10, 32'h0000_0060, "R9 ovf set");
        repeat (4) @(posedge clk);
        rd(8'h10, 32'h0000_0060, "R9 ovf sticky");
        wr(8'h14, 32'h0000_0040);
        rd(8'h10, 32'h0000_0020, "R9 ovf cleared");
        irq_is(0, "R11 irq drops");
        wr(8'h44, 32'h0000_0800);
        pulse_ovf();
        irq_is(0, "R11 ovf gated");
        rd(8'h10, 32'h0000_0060, "R11 gated flag set");
        pulse_frm();
        irq_is(1, "R11 frm irq");
        wr(8'h14, 32'h0000_1040);
        irq_is(0, "R11 irq after clear");
        rd(8'h10, 32'h0000_0020, "R9 both cleared");
        // R10 collision
        @(posedge clk); #1;
        wr_en = 1; addr = 8'h14; wdata = 32'h0000_0100; urun_evt = 1;
        @(posedge clk); #1;
        wr_en = 0; urun_evt = 0;
        rd(8'h10, 32'h0000_0120, "R10 event wins");
        irq_is(1, "R10 irq held");
        wr(8'h14, 32'h0000_0100);
        rd(8'h10, 32'h0000_0020, "R10 later clear");
        // R12 reserved
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_A001, "R12 ctrl kept");
        rd(8'h40, 32'h0000_1400, "R12 ctrl2 kept");
        rd(8'h30, 32'h0000_0123, "R12 baud kept");
        rd(8'h24, 32'h0, "R12 read 0x24");
        rd(8'h3C, 32'h0, "R12 read 0x3C");
        rd(8'h60, 32'h0, "R12 read 0x60");
        // R13 data buffer
        @(posedge clk); #1;
        wr_en = 1; addr = 8'h20; wdata = 32'hCAFE_0042;
        @(negedge clk);
        check(tx_push === 1'b1, "R13 push strobe", {31'b0, tx_push}, 32'h1);
        check(tx_wdata === 32'hCAFE_0042, "R13 push data", tx_wdata, 32'hCAFE_0042);
        @(posedge clk); #1;
        wr_en = 0;
        @(negedge clk);
        check(tx_push === 1'b0, "R13 push one cycle", {31'b0, tx_push}, 32'h0);
        rx_rdata = 32'h1234_5678;
        rd(8'h20, 32'h1234_5678, "R13 rx data");
        @(posedge clk); #1;
        rd_en = 1; addr = 8'h20;
        exp_q.push_back(32'h1234_5678); tag_q.push_back("R13 rx data again");
        @(negedge clk);
        check(rx_pop === 1'b1, "R13 pop strobe", {31'b0, rx_pop}, 32'h1);
        @(posedge clk); #1;
        rd_en = 0;
        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule